// File: doc/BRIEF.md
# Per-Pin GPIO Source Crossbar

This block sits between a bank of twelve front-panel GPIO pads and the logic that wants to use them. Each pin is owned independently by either the processor-side register bank or one of four radio channels. Software picks the owner of every pin through two configuration registers. The first is an ownership mask with one bit per pin. The second is a packed selector word that holds a two-bit radio number for each pin.

For each pin, the crossbar forwards the output value and the output-enable of the chosen owner to the pad. The synchronized pad input goes back to every source, whether or not that source owns the pin. The same synchronized input can also be read through a read-only register.

Configuration uses a simple word interface: a write strobe, a two-bit address and 32-bit write data. Read data is a combinational function of the address and the stored state.

Top module: `gpio_xbar`

## Requirements
- R1: After reset, the ownership mask (address 0) and the selector word (address 1) both read as zero. Every pad then carries radio 0's output value and output-enable.
- R2: A pin whose ownership bit is 1 drives the pad from the processor-side output value and output-enable for that pin.
- R3: A pin whose ownership bit is 0 is driven by the radio named in selector bits [2i+1:2i]. Codes 0, 1, 2 and 3 select radio 0, 1, 2 and 3. Radio r's bit for pin i sits at position r*12+i of the packed radio buses.
- R4: While a pin's ownership bit is 1, its selector field has no effect on that pin's pad value or enable.
- R5: The pad output-enable of every pin always comes from the same source as its pad output value.
- R6: A write to address 0 stores bits [11:0] into the ownership mask. A write to address 1 stores bits [23:0] into the selector word. Reading either address returns the stored value.
- R7: Bits above 11 of the ownership mask and above 23 of the selector word ignore writes and always read as zero.
- R8: A pad input change becomes visible on the processor input bus, on every radio input slice, and at read address 2 after exactly two rising clock edges.
- R9: Writes to address 2 or 3 change neither configuration register.
- R10: A configuration write takes effect on the pads right after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 selector, 2 pin input, 3 unused |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| ps_out_i | input | 12 | Processor-side output values |
| ps_oe_i | input | 12 | Processor-side output-enables |
| radio_out_i | input | 48 | Radio output values, radio r at bits [r*12+11:r*12] |
| radio_oe_i | input | 48 | Radio output-enables, same packing |
| pad_in_i | input | 12 | Raw pad input values |
| pad_out_o | output | 12 | Pad output values |
| pad_oe_o | output | 12 | Pad output-enables |
| ps_in_o | output | 12 | Synchronized pad inputs to the processor side |
| radio_in_o | output | 48 | Synchronized pad inputs to each radio, same packing |

## Verification
The routing and readback paths have no pipeline stage. Pad values and read data are therefore due in the same cycle as a source change, and in the cycle right after the edge that captures a write. The bench drives at the falling edge and samples one nanosecond later, so one rising edge lies between a write and its check. The synchronized inputs are due two rising edges after the pad changes. The bench checks them after one edge, where the old value must still show, and again after the second edge, where the new value must have arrived.

// File: rtl/gpio_xbar_pkg.sv
package gpio_xbar_pkg;
  localparam int unsigned XB_ADDR_W = 2;

  typedef enum logic [XB_ADDR_W-1:0] {
    XB_MASTER = 2'd0,
    XB_RSEL   = 2'd1,
    XB_PINS   = 2'd2,
    XB_RSVD   = 2'd3
  } xb_addr_e;

  function automatic int unsigned sel_width(input int unsigned n_src);
    return (n_src > 1) ? $clog2(n_src) : 1;
  endfunction
endpackage

// File: rtl/gpio_xbar_cfg.sv
module gpio_xbar_cfg
  import gpio_xbar_pkg::*;
#(
  parameter int unsigned NUM_PINS = 12,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [XB_ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [NUM_PINS-1:0]       pin_in_i,
  output logic [NUM_PINS-1:0]       master_o,
  output logic [NUM_PINS*SEL_W-1:0] sel_o,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam int unsigned RSEL_W = NUM_PINS * SEL_W;

  logic [NUM_PINS-1:0] master_q;
  logic [RSEL_W-1:0]   sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= '0;
      sel_q    <= '0;
    end else if (we_i) begin
      if (addr_i == XB_MASTER) master_q <= wdata_i[NUM_PINS-1:0];
      if (addr_i == XB_RSEL)   sel_q    <= wdata_i[RSEL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      XB_MASTER: rdata_o[NUM_PINS-1:0] = master_q;
      XB_RSEL:   rdata_o[RSEL_W-1:0]   = sel_q;
      XB_PINS:   rdata_o[NUM_PINS-1:0] = pin_in_i;
      default:   rdata_o = '0;
    endcase
  end

  assign master_o = master_q;
  assign sel_o    = sel_q;
endmodule

// File: rtl/gpio_xbar_pin_mux.sv
module gpio_xbar_pin_mux #(
  parameter int unsigned NUM_RADIOS = 4,
  parameter int unsigned SEL_W      = 2
) (
  input  logic                  master_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  ps_out_i,
  input  logic                  ps_oe_i,
  input  logic [NUM_RADIOS-1:0] radio_out_i,
  input  logic [NUM_RADIOS-1:0] radio_oe_i,
  output logic                  pad_out_o,
  output logic                  pad_oe_o
);
  logic r_out, r_oe;

  // Codes beyond the radio count park the pin undriven
  always_comb begin
    r_out = 1'b0;
    r_oe  = 1'b0;
    for (int r = 0; r < NUM_RADIOS; r++) begin
      if (sel_i == SEL_W'(r)) begin
        r_out = radio_out_i[r];
        r_oe  = radio_oe_i[r];
      end
    end
  end

  assign pad_out_o = master_i ? ps_out_i : r_out;
  assign pad_oe_o  = master_i ? ps_oe_i  : r_oe;
endmodule

// File: rtl/gpio_xbar_in_sync.sv
module gpio_xbar_in_sync #(
  parameter int unsigned NUM_PINS   = 12,
  parameter int unsigned NUM_RADIOS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PINS-1:0]            pad_in_i,
  output logic [NUM_PINS-1:0]            sync_o,
  output logic [NUM_RADIOS*NUM_PINS-1:0] fan_o
);
  logic [NUM_PINS-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  for (genvar r = 0; r < NUM_RADIOS; r++) begin : g_fan
    assign fan_o[r*NUM_PINS +: NUM_PINS] = sync_q;
  end
endmodule

// File: rtl/gpio_xbar.sv
module gpio_xbar
  import gpio_xbar_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 12,
  parameter int unsigned NUM_RADIOS = 4,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_we_i,
  input  logic [XB_ADDR_W-1:0]           reg_addr_i,
  input  logic [DATA_W-1:0]              reg_wdata_i,
  output logic [DATA_W-1:0]              reg_rdata_o,
  input  logic [NUM_PINS-1:0]            ps_out_i,
  input  logic [NUM_PINS-1:0]            ps_oe_i,
  input  logic [NUM_RADIOS*NUM_PINS-1:0] radio_out_i,
  input  logic [NUM_RADIOS*NUM_PINS-1:0] radio_oe_i,
  input  logic [NUM_PINS-1:0]            pad_in_i,
  output logic [NUM_PINS-1:0]            pad_out_o,
  output logic [NUM_PINS-1:0]            pad_oe_o,
  output logic [NUM_PINS-1:0]            ps_in_o,
  output logic [NUM_RADIOS*NUM_PINS-1:0] radio_in_o
);
  localparam int unsigned SEL_W = sel_width(NUM_RADIOS);

  logic [NUM_PINS-1:0]       master_w;
  logic [NUM_PINS*SEL_W-1:0] sel_w;
  logic [NUM_PINS-1:0]       sync_w;

  gpio_xbar_cfg #(
    .NUM_PINS (NUM_PINS),
    .SEL_W    (SEL_W),
    .DATA_W   (DATA_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .pin_in_i (sync_w),
    .master_o (master_w),
    .sel_o    (sel_w),
    .rdata_o  (reg_rdata_o)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_RADIOS-1:0] r_out, r_oe;
    for (genvar r = 0; r < NUM_RADIOS; r++) begin : g_gather
      assign r_out[r] = radio_out_i[r*NUM_PINS + p];
      assign r_oe[r]  = radio_oe_i[r*NUM_PINS + p];
    end
    gpio_xbar_pin_mux #(
      .NUM_RADIOS (NUM_RADIOS),
      .SEL_W      (SEL_W)
    ) u_mux (
      .master_i    (master_w[p]),
      .sel_i       (sel_w[p*SEL_W +: SEL_W]),
      .ps_out_i    (ps_out_i[p]),
      .ps_oe_i     (ps_oe_i[p]),
      .radio_out_i (r_out),
      .radio_oe_i  (r_oe),
      .pad_out_o   (pad_out_o[p]),
      .pad_oe_o    (pad_oe_o[p])
    );
  end

  gpio_xbar_in_sync #(
    .NUM_PINS   (NUM_PINS),
    .NUM_RADIOS (NUM_RADIOS)
  ) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pad_in_i (pad_in_i),
    .sync_o   (sync_w),
    .fan_o    (radio_in_o)
  );

  assign ps_in_o = sync_w;
endmodule

// File: rtl/gpio_xbar_chk.sv
module gpio_xbar_chk
  import gpio_xbar_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 12,
  parameter int unsigned NUM_RADIOS = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SEL_W      = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           reg_we_i,
  input logic [XB_ADDR_W-1:0]           reg_addr_i,
  input logic [DATA_W-1:0]              reg_wdata_i,
  input logic [DATA_W-1:0]              reg_rdata_o,
  input logic [NUM_PINS-1:0]            master,
  input logic [NUM_PINS*SEL_W-1:0]      sel,
  input logic [NUM_PINS-1:0]            ps_out_i,
  input logic [NUM_PINS-1:0]            ps_oe_i,
  input logic [NUM_RADIOS*NUM_PINS-1:0] radio_out_i,
  input logic [NUM_RADIOS*NUM_PINS-1:0] radio_oe_i,
  input logic [NUM_PINS-1:0]            pad_in_i,
  input logic [NUM_PINS-1:0]            pad_out_o,
  input logic [NUM_PINS-1:0]            pad_oe_o,
  input logic [NUM_PINS-1:0]            ps_in_o,
  input logic [NUM_RADIOS*NUM_PINS-1:0] radio_in_o
);
  localparam int unsigned RSEL_W = NUM_PINS * SEL_W;

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_wr_master_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == XB_MASTER) |=> master == $past(reg_wdata_i[NUM_PINS-1:0]));

  p_wr_rsel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == XB_RSEL) |=> sel == $past(reg_wdata_i[RSEL_W-1:0]));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && (reg_addr_i == XB_MASTER || reg_addr_i == XB_RSEL))
      |=> ($stable(master) && $stable(sel)));

  p_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == XB_MASTER) |-> reg_rdata_o[DATA_W-1:NUM_PINS] == '0);

  p_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> ps_in_o == $past(pad_in_i, 2));

  for (genvar r = 0; r < NUM_RADIOS; r++) begin : g_fan
    p_fanout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      radio_in_o[r*NUM_PINS +: NUM_PINS] == ps_in_o);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SEL_W-1:0] fld;
    logic exp_out, exp_oe;
    assign fld = sel[p*SEL_W +: SEL_W];
    always_comb begin
      exp_out = 1'b0;
      exp_oe  = 1'b0;
      for (int r = 0; r < NUM_RADIOS; r++) begin
        if (fld == SEL_W'(r)) begin
          exp_out = radio_out_i[r*NUM_PINS + p];
          exp_oe  = radio_oe_i[r*NUM_PINS + p];
        end
      end
    end

    p_ps_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      master[p] |-> (pad_out_o[p] == ps_out_i[p] && pad_oe_o[p] == ps_oe_i[p]));

    // r5: enable tracks the same radio as the value
    p_radio_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !master[p] |-> (pad_out_o[p] == exp_out && pad_oe_o[p] == exp_oe));
  end
endmodule

bind gpio_xbar gpio_xbar_chk #(
  .NUM_PINS   (NUM_PINS),
  .NUM_RADIOS (NUM_RADIOS),
  .DATA_W     (DATA_W),
  .SEL_W      (SEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .master      (master_w),
  .sel         (sel_w),
  .ps_out_i    (ps_out_i),
  .ps_oe_i     (ps_oe_i),
  .radio_out_i (radio_out_i),
  .radio_oe_i  (radio_oe_i),
  .pad_in_i    (pad_in_i),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o),
  .ps_in_o     (ps_in_o),
  .radio_in_o  (radio_in_o)
);

// File: tb/tb_gpio_xbar.sv
module tb_gpio_xbar;
  localparam int NP = 12;
  localparam int NR = 4;

  localparam int K_OUT  = 0;
  localparam int K_OE   = 1;
  localparam int K_RD   = 2;
  localparam int K_PSIN = 3;
  localparam int K_RIN  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] ps_out = '0, ps_oe = '0;
  logic [NR*NP-1:0] r_out = '0, r_oe = '0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, ps_in;
  logic [NR*NP-1:0] r_in;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [NP-1:0] m_master = '0;
  logic [2*NP-1:0] m_sel = '0;

  typedef struct {
    int          kind;
    logic [47:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  event sample_ev;

  always #4 clk = ~clk;

  gpio_xbar dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .ps_out_i    (ps_out),
    .ps_oe_i     (ps_oe),
    .radio_out_i (r_out),
    .radio_oe_i  (r_oe),
    .pad_in_i    (pad_in),
    .pad_out_o   (pad_out),
    .pad_oe_o    (pad_oe),
    .ps_in_o     (ps_in),
    .radio_in_o  (r_in)
  );

  // Monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [47:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_OUT:   act = {36'b0, pad_out};
          K_OE:    act = {36'b0, pad_oe};
          K_RD:    act = {16'b0, rdata};
          K_PSIN:  act = {36'b0, ps_in};
          default: act = r_in;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [47:0] exp, input string tag);
    sb.push_back('{kind, exp, tag});
  endtask

  task automatic flush();
    #1;
    ->sample_ev;
    #1;
  endtask

  function automatic logic [NP-1:0] route(input logic [NP-1:0] ps, input logic [NR*NP-1:0] rv);
    logic [NP-1:0] res;
    for (int i = 0; i < NP; i++) begin
      int code;
      code = int'(m_sel[2*i +: 2]);
      res[i] = m_master[i] ? ps[i] : rv[code*NP + i];
    end
    return res;
  endfunction

  task automatic check_pads(input string tag);
    push(K_OUT, {36'b0, route(ps_out, r_out)}, tag);
    push(K_OE,  {36'b0, route(ps_oe, r_oe)}, tag);
    flush();
  endtask

  task automatic check_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    push(K_RD, {16'b0, exp}, tag);
    flush();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 2'd0) m_master = d[NP-1:0];
    if (a == 2'd1) m_sel = d[2*NP-1:0];
  endtask

  initial begin
    ps_out = 12'h6A5; ps_oe = 12'h9C3;
    r_out = {12'h5DB, 12'hA69, 12'h3C5, 12'h0F0};
    r_oe  = {12'hCCC, 12'h333, 12'h0FF, 12'hF00};
    #10;
    // R1: state under reset
    check_rd(2'd0, 32'h0, "R1 mask reset");
    check_rd(2'd1, 32'h0, "R1 sel reset");
    push(K_OUT, {36'b0, 12'h0F0}, "R1 pads from radio0");
    push(K_OE,  {36'b0, 12'hF00}, "R1 oe from radio0");
    flush();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R3, R10: mixed radio codes 0,1,2,3 repeating, checked one edge after write
    wr(2'd1, 32'h00E4E4E4);
    check_pads("R3 R10 radio select mix");
    // R2: all pins to processor
    wr(2'd0, 32'h00000FFF);
    check_pads("R2 processor owns all");
    // R4: selector all-3 ignored on processor pins
    wr(2'd1, 32'h00FFFFFF);
    wr(2'd0, 32'h00000A5A);
    check_pads("R4 R5 partial ownership");
    // R5: change sources, same routing
    ps_out = 12'h1E7; ps_oe = 12'h248;
    r_out = {12'hF0F, 12'h777, 12'h888, 12'h135};
    r_oe  = {12'h00F, 12'hAAA, 12'h555, 12'hBEE};
    check_pads("R5 R4 new source values");
    wr(2'd0, 32'h0);
    check_pads("R3 all radio3");

    // R6, R7: readback and upper-bit masking
    wr(2'd0, 32'hFFFFF123);
    check_rd(2'd0, 32'h00000123, "R6 R7 mask readback");
    wr(2'd1, 32'hAB123456);
    check_rd(2'd1, 32'h00123456, "R6 R7 sel readback");
    check_pads("R3 R2 after masked writes");

    // R9: unused addresses leave config alone
    wr(2'd2, 32'hFFFFFFFF);
    wr(2'd3, 32'hFFFFFFFF);
    check_rd(2'd0, 32'h00000123, "R9 mask kept");
    check_rd(2'd1, 32'h00123456, "R9 sel kept");
    check_pads("R9 pads kept");

    // R8: two-edge input synchronizer
    @(negedge clk);
    pad_in = 12'hABC;
    @(negedge clk);
    push(K_PSIN, 48'h0, "R8 one edge old value");
    flush();
    @(negedge clk);
    push(K_PSIN, {36'b0, 12'hABC}, "R8 two edges");
    push(K_RIN, {4{12'hABC}}, "R8 radio fanout");
    flush();
    check_rd(2'd2, 32'h00000ABC, "R8 input register");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule